// File: doc/BRIEF.md
# Serial Engine Status and Service-Flag Unit

This block watches the data path of a FIFO-based serial engine and turns what it sees into status flags, an error record and a single level interrupt. The data path reports each word entering or leaving the input FIFO and the output FIFO, plus serial-clock overrun and underrun events. From these pulses the block keeps its own copy of both FIFO fill levels and two word counters. It derives full and not-empty bits, service flags, block requests, completion flags and error flags. Software sees everything through a small synchronous register port.

Two transfer styles are supported and selected by the `mode_block` pin. In word-by-word mode each accepted input word, or the draining of the output FIFO, raises a service flag. In block mode the service flags follow block requests, which hold while a whole block of words can be read or written. An input service flag cleared during such a request comes back on the next cycle. Service and completion flags clear when a one is written to their bit. The service flags can be kept out of the interrupt by a mask. FIFO errors and serial-clock errors are latched only when their enable bit is set.

Register word addresses: 0 status, 1 service mask, 2 FIFO errors, 3 FIFO error enables, 4 clock errors, 5 clock error enables, 6 input word limit, 7 output word limit.

Top module: `svc_status_unit`

## Requirements
- R1: After reset, the status, FIFO error and clock error registers read zero and `irq` is low.
- R2: Status bit 5 (bit 4) is set while the input (output) FIFO holds at least one word, and bit 7 (bit 6) while it holds DEPTH words.
- R3: With `mode_block` low, status bit 9 (input service) sets on every accepted input word, and bit 8 (output service) sets when an accepted output pop leaves the output FIFO empty.
- R4: Writing 1 to status bit 9 or 8 clears that flag, and writing 0 leaves it unchanged; if a set condition occurs in the same cycle as the clear, the flag stays set.
- R5: With `mode_block` high, status bit 13 is set while the input level is at least BLK, and bit 12 is set while the free output space is at least BLK, the output limit is nonzero and the output count has not reached it.
- R6: With `mode_block` high, the input service flag sets on every cycle that bit 13 holds, so a clear has no lasting effect while a block is available.
- R7: Status bit 11 (bit 10) sets when the accepted input push (output pop) count reaches a nonzero input (output) limit. A limit of zero disables the flag, writing a limit restarts its count, and writing 1 to the bit clears it.
- R8: FIFO error register bits are: 5 push to a full output FIFO, 4 pop from an empty input FIFO, 3 pop from an empty output FIFO, 2 push to a full input FIFO. Each latches only if the same bit of the enable register is set, clears on write-one, and the rejected operation leaves the level unchanged.
- R9: Clock error register bit 1 latches `sclk_over` and bit 0 latches `sclk_under`, each only if the same bit of the clock enable register is set; writing 1 clears.
- R10: Mask register bits 9 and 8 keep the input and output service flags out of `irq`, while the flags still read back in the status register.
- R11: `irq` is registered, high one cycle after any unmasked service flag, done flag or latched error is set.
- R12: `rd_data` presents the addressed register one cycle after `rd_en`; the mask and limit registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_block | input | 1 | 1 selects block mode, 0 word-by-word mode |
| in_push | input | 1 | Shifter delivers a word into the input FIFO |
| in_pop | input | 1 | Software takes a word from the input FIFO |
| out_push | input | 1 | Software puts a word into the output FIFO |
| out_pop | input | 1 | Shifter takes a word from the output FIFO |
| sclk_over | input | 1 | Serial-clock overrun event |
| sclk_under | input | 1 | Serial-clock underrun event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Registered level interrupt |

## Verification
An event pulse captured on edge k moves the fill level and any word-mode or completion flag on that same edge. A block request and the service flag that follows it settle one edge later, and `irq` rises one edge after its source flag. Read data appears on the edge that samples `rd_en`. The bench drives all inputs on falling edges and lets two idle cycles pass before each register read, so every flag has settled. The interrupt-latency check samples `irq` just after the capturing edge and again after the following edge, and expects low and then high.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] A_STAT   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FERR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_FEN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CERR   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CEN    = 3'd5;
  localparam logic [ADDR_W-1:0] A_INLIM  = 3'd6;
  localparam logic [ADDR_W-1:0] A_OUTLIM = 3'd7;

  localparam int B_IN_BREQ  = 13;
  localparam int B_OUT_BREQ = 12;
  localparam int B_IN_DONE  = 11;
  localparam int B_OUT_DONE = 10;
  localparam int B_IN_SVC   = 9;
  localparam int B_OUT_SVC  = 8;
  localparam int B_IN_FULL  = 7;
  localparam int B_OUT_FULL = 6;
  localparam int B_IN_NE    = 5;
  localparam int B_OUT_NE   = 4;

  localparam int FERR_LSB = 2;
  localparam int FERR_N   = 4;
  localparam int CERR_N   = 2;
endpackage

// File: rtl/svc_level_track.sv
module svc_level_track #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_err,
  output logic          pop_err
);
  logic push_ok, pop_ok;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign push_ok  = push & ~full;
  assign pop_ok   = pop & ~empty;
  assign push_err = push & full;
  assign pop_err  = pop & empty;

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else if (push_ok & ~pop_ok) level <= level + LW'(1);
    else if (pop_ok & ~push_ok) level <= level - LW'(1);
  end

  // R2
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(level));
endmodule

// File: rtl/svc_word_count.sv
module svc_word_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          hit,
  output logic          reached
);
  logic [CW-1:0] cnt;
  logic          armed;

  assign armed   = (limit != '0);
  assign reached = armed & (cnt == limit);
  assign hit     = step & armed & ~reached & ((cnt + CW'(1)) == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (step && armed && !reached) cnt <= cnt + CW'(1);
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt <= limit));
endmodule

// File: rtl/svc_err_latch.sv
module svc_err_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] en,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags
);
  logic [W-1:0] clr_v;

  assign clr_v = clr_wr ? clr_bits : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= (flags[i] & ~clr_v[i]) | (evt[i] & en[i]);
    end
  end

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|(evt & en)) |=> ((flags & $past(evt & en)) == $past(evt & en)));
endmodule

// File: rtl/svc_status_unit.sv
module svc_status_unit
  import svc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BLK   = 4,
  parameter int CW    = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_block,
  input  logic              in_push,
  input  logic              in_pop,
  input  logic              out_push,
  input  logic              out_pop,
  input  logic              sclk_over,
  input  logic              sclk_under,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  logic [LW-1:0] in_level, out_level;
  logic in_full, in_empty, in_push_err, in_pop_err;
  logic out_full, out_empty, out_push_err, out_pop_err;

  svc_level_track #(.DEPTH(DEPTH)) u_in_lvl (
    .clk(clk), .rst(rst), .push(in_push), .pop(in_pop),
    .level(in_level), .full(in_full), .empty(in_empty),
    .push_err(in_push_err), .pop_err(in_pop_err));

  svc_level_track #(.DEPTH(DEPTH)) u_out_lvl (
    .clk(clk), .rst(rst), .push(out_push), .pop(out_pop),
    .level(out_level), .full(out_full), .empty(out_empty),
    .push_err(out_push_err), .pop_err(out_pop_err));

  logic in_push_ok, out_push_ok, out_pop_ok;
  assign in_push_ok  = in_push & ~in_full;
  assign out_push_ok = out_push & ~out_full;
  assign out_pop_ok  = out_pop & ~out_empty;

  logic wr_stat, wr_mask, wr_ferr, wr_fen, wr_cerr, wr_cen, wr_inlim, wr_outlim;
  assign wr_stat   = wr_en & (wr_addr == A_STAT);
  assign wr_mask   = wr_en & (wr_addr == A_MASK);
  assign wr_ferr   = wr_en & (wr_addr == A_FERR);
  assign wr_fen    = wr_en & (wr_addr == A_FEN);
  assign wr_cerr   = wr_en & (wr_addr == A_CERR);
  assign wr_cen    = wr_en & (wr_addr == A_CEN);
  assign wr_inlim  = wr_en & (wr_addr == A_INLIM);
  assign wr_outlim = wr_en & (wr_addr == A_OUTLIM);

  logic [CW-1:0] in_lim, out_lim;
  logic [1:0]    svc_mask;
  logic [FERR_N-1:0] ferr_en, ferr;
  logic [CERR_N-1:0] cerr_en, cerr;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_lim   <= '0;
      out_lim  <= '0;
      svc_mask <= '0;
      ferr_en  <= '0;
      cerr_en  <= '0;
    end else begin
      if (wr_inlim)  in_lim   <= wr_data[CW-1:0];
      if (wr_outlim) out_lim  <= wr_data[CW-1:0];
      if (wr_mask)   svc_mask <= {wr_data[B_IN_SVC], wr_data[B_OUT_SVC]};
      if (wr_fen)    ferr_en  <= wr_data[FERR_LSB +: FERR_N];
      if (wr_cen)    cerr_en  <= wr_data[CERR_N-1:0];
    end
  end

  logic in_hit, in_reached, out_hit, out_reached;

  svc_word_count #(.CW(CW)) u_in_cnt (
    .clk(clk), .rst(rst), .restart(wr_inlim), .step(in_push_ok),
    .limit(in_lim), .hit(in_hit), .reached(in_reached));

  svc_word_count #(.CW(CW)) u_out_cnt (
    .clk(clk), .rst(rst), .restart(wr_outlim), .step(out_pop_ok),
    .limit(out_lim), .hit(out_hit), .reached(out_reached));

  logic [FERR_N-1:0] ferr_evt;
  assign ferr_evt = {out_push_err, in_pop_err, out_pop_err, in_push_err};

  svc_err_latch #(.W(FERR_N)) u_ferr (
    .clk(clk), .rst(rst), .evt(ferr_evt), .en(ferr_en),
    .clr_wr(wr_ferr), .clr_bits(wr_data[FERR_LSB +: FERR_N]), .flags(ferr));

  svc_err_latch #(.W(CERR_N)) u_cerr (
    .clk(clk), .rst(rst), .evt({sclk_over, sclk_under}), .en(cerr_en),
    .clr_wr(wr_cerr), .clr_bits(wr_data[CERR_N-1:0]), .flags(cerr));

  logic in_breq, out_breq;
  assign in_breq  = mode_block & (in_level >= LW'(BLK));
  assign out_breq = mode_block & (out_level <= LW'(DEPTH - BLK)) &
                    (out_lim != '0) & ~out_reached;

  logic in_svc_set, out_svc_set;
  assign in_svc_set  = mode_block ? in_breq : in_push_ok;
  assign out_svc_set = mode_block ? out_breq
                     : (out_pop_ok & ~out_push_ok & (out_level == LW'(1)));

  logic in_svc, out_svc, in_done, out_done;
  logic clr_in_svc, clr_out_svc, clr_in_done, clr_out_done;
  assign clr_in_svc   = wr_stat & wr_data[B_IN_SVC];
  assign clr_out_svc  = wr_stat & wr_data[B_OUT_SVC];
  assign clr_in_done  = wr_stat & wr_data[B_IN_DONE];
  assign clr_out_done = wr_stat & wr_data[B_OUT_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_svc   <= 1'b0;
      out_svc  <= 1'b0;
      in_done  <= 1'b0;
      out_done <= 1'b0;
    end else begin
      in_svc   <= (in_svc & ~clr_in_svc) | in_svc_set;
      out_svc  <= (out_svc & ~clr_out_svc) | out_svc_set;
      in_done  <= (in_done & ~clr_in_done) | in_hit;
      out_done <= (out_done & ~clr_out_done) | out_hit;
    end
  end

  logic [REG_W-1:0] stat_v;
  always_comb begin
    stat_v             = '0;
    stat_v[B_IN_BREQ]  = in_breq;
    stat_v[B_OUT_BREQ] = out_breq;
    stat_v[B_IN_DONE]  = in_done;
    stat_v[B_OUT_DONE] = out_done;
    stat_v[B_IN_SVC]   = in_svc;
    stat_v[B_OUT_SVC]  = out_svc;
    stat_v[B_IN_FULL]  = in_full;
    stat_v[B_OUT_FULL] = out_full;
    stat_v[B_IN_NE]    = ~in_empty;
    stat_v[B_OUT_NE]   = ~out_empty;
  end

  logic [REG_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_STAT:   rd_next = stat_v;
      A_MASK:   begin
                  rd_next[B_IN_SVC]  = svc_mask[1];
                  rd_next[B_OUT_SVC] = svc_mask[0];
                end
      A_FERR:   rd_next[FERR_LSB +: FERR_N] = ferr;
      A_FEN:    rd_next[FERR_LSB +: FERR_N] = ferr_en;
      A_CERR:   rd_next[CERR_N-1:0] = cerr;
      A_CEN:    rd_next[CERR_N-1:0] = cerr_en;
      A_INLIM:  rd_next[CW-1:0] = in_lim;
      A_OUTLIM: rd_next[CW-1:0] = out_lim;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_next;
      irq <= (in_svc & ~svc_mask[1]) | (out_svc & ~svc_mask[0]) |
             in_done | out_done | (|ferr) | (|cerr);
    end
  end

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_svc && !svc_mask[1]) |=> irq);

  // R11
  irq_err_chk: assert property (@(posedge clk) disable iff (rst)
    (|ferr || |cerr) |=> irq);

  // R6
  blk_resvc_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_block && in_level >= LW'(BLK)) |=> in_svc);

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((&svc_mask) && !in_done && !out_done && !(|ferr) && !(|cerr)) |=> !irq);
endmodule

// File: tb/sim_svc_status_unit.sv
module sim_svc_status_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_block = 1'b0;
  logic in_push = 1'b0, in_pop = 1'b0, out_push = 1'b0, out_pop = 1'b0;
  logic sclk_over = 1'b0, sclk_under = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  svc_status_unit #(.DEPTH(8), .BLK(4), .CW(16)) u0 (
    .clk(clk), .rst(rst), .mode_block(mode_block),
    .in_push(in_push), .in_pop(in_pop), .out_push(out_push), .out_pop(out_pop),
    .sclk_over(sclk_over), .sclk_under(sclk_under),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mode_block = 1'b0;
    in_push = 0; in_pop = 0; out_push = 0; out_pop = 0;
    sclk_over = 0; sclk_under = 0; wr_en = 0; rd_en = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    idle(2);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a,
                         input logic [15:0] m, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v & m, exp);
  endtask

  task automatic push_in(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_push = 1'b1;
      @(negedge clk); in_push = 1'b0;
    end
  endtask
  task automatic pop_in(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_pop = 1'b1;
      @(negedge clk); in_pop = 1'b0;
    end
  endtask
  task automatic push_out(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); out_push = 1'b1;
      @(negedge clk); out_push = 1'b0;
    end
  endtask
  task automatic pop_out(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); out_pop = 1'b1;
      @(negedge clk); out_pop = 1'b0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk_reg("R1 status", 3'd0, 16'hFFFF, 16'h0000);
    chk_reg("R1 fifo errors", 3'd2, 16'hFFFF, 16'h0000);
    chk_reg("R1 clock errors", 3'd4, 16'hFFFF, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_word_mode();
    do_reset();
    @(negedge clk); in_push = 1'b1;
    @(posedge clk); #1; in_push = 1'b0;
    check("R11 irq not yet", {15'd0, irq}, 16'd0);
    @(posedge clk); #1;
    check("R11 irq one cycle later", {15'd0, irq}, 16'd1);
    chk_reg("R3 R2 input svc and not-empty", 3'd0, 16'h0220, 16'h0220);
    wr(3'd0, 16'h0200);
    chk_reg("R4 write-one clears", 3'd0, 16'h0200, 16'h0000);
    check("R4 irq drops", {15'd0, irq}, 16'd0);
    push_in(1);
    wr(3'd0, 16'h0000);
    chk_reg("R4 write-zero keeps", 3'd0, 16'h0200, 16'h0200);
    wr(3'd0, 16'h0200);
    @(negedge clk);
    in_push = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0200;
    @(negedge clk);
    in_push = 1'b0; wr_en = 1'b0;
    chk_reg("R4 set wins over clear", 3'd0, 16'h0200, 16'h0200);
    push_out(2);
    chk_reg("R2 output not-empty", 3'd0, 16'h0110, 16'h0010);
    pop_out(2);
    chk_reg("R3 output svc on drain", 3'd0, 16'h0110, 16'h0100);
  endtask

  task automatic t_errors();
    do_reset();
    wr(3'd3, 16'h003C);
    push_in(8);
    chk_reg("R2 input full", 3'd0, 16'h00A0, 16'h00A0);
    push_in(1);
    chk_reg("R8 input overrun", 3'd2, 16'hFFFF, 16'h0004);
    pop_in(7);
    chk_reg("R8 level held on overrun", 3'd0, 16'h0020, 16'h0020);
    pop_in(2);
    chk_reg("R8 input underrun", 3'd2, 16'hFFFF, 16'h0014);
    check("R11 irq on error", {15'd0, irq}, 16'd1);
    wr(3'd2, 16'h0014);
    chk_reg("R8 errors cleared", 3'd2, 16'hFFFF, 16'h0000);
    wr(3'd3, 16'h0000);
    pop_out(1);
    chk_reg("R8 disabled error ignored", 3'd2, 16'hFFFF, 16'h0000);
    wr(3'd3, 16'h0008);
    pop_out(1);
    chk_reg("R8 output underrun", 3'd2, 16'hFFFF, 16'h0008);
  endtask

  task automatic t_mask();
    do_reset();
    wr(3'd1, 16'h0200);
    push_in(1);
    chk_reg("R10 flag visible under mask", 3'd0, 16'h0200, 16'h0200);
    check("R10 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd1, 16'h0000);
    idle(2);
    check("R10 irq after unmask", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_clock_err();
    do_reset();
    @(negedge clk); sclk_over = 1; sclk_under = 1;
    @(negedge clk); sclk_over = 0; sclk_under = 0;
    chk_reg("R9 disabled", 3'd4, 16'hFFFF, 16'h0000);
    wr(3'd5, 16'h0001);
    @(negedge clk); sclk_over = 1; sclk_under = 1;
    @(negedge clk); sclk_over = 0; sclk_under = 0;
    chk_reg("R9 underrun only", 3'd4, 16'hFFFF, 16'h0001);
    check("R11 irq clock error", {15'd0, irq}, 16'd1);
    wr(3'd4, 16'h0001);
    chk_reg("R9 cleared", 3'd4, 16'hFFFF, 16'h0000);
  endtask

  task automatic t_block();
    do_reset();
    mode_block = 1'b1;
    chk_reg("R5 no requests idle", 3'd0, 16'h3000, 16'h0000);
    push_in(4);
    chk_reg("R5 input block request", 3'd0, 16'h2200, 16'h2200);
    wr(3'd0, 16'h0200);
    chk_reg("R6 svc re-sets", 3'd0, 16'h0200, 16'h0200);
    pop_in(1);
    wr(3'd0, 16'h0200);
    chk_reg("R5 R6 request gone", 3'd0, 16'h2200, 16'h0000);
    wr(3'd7, 16'd3);
    chk_reg("R5 output block request", 3'd0, 16'h1100, 16'h1100);
    push_out(3);
    pop_out(3);
    chk_reg("R7 output done", 3'd0, 16'h1C00, 16'h0400);
    wr(3'd0, 16'h0400);
    chk_reg("R7 output done cleared", 3'd0, 16'h0400, 16'h0000);
    wr(3'd6, 16'd2);
    push_in(2);
    chk_reg("R7 input done", 3'd0, 16'h0800, 16'h0800);
    wr(3'd6, 16'd0);
    wr(3'd0, 16'h0800);
    push_in(1);
    chk_reg("R7 zero limit disables", 3'd0, 16'h0800, 16'h0000);
  endtask

  task automatic t_readback();
    do_reset();
    wr(3'd6, 16'd5);
    wr(3'd1, 16'h0300);
    chk_reg("R12 input limit", 3'd6, 16'hFFFF, 16'd5);
    chk_reg("R12 mask", 3'd1, 16'hFFFF, 16'h0300);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_word_mode();
    t_errors();
    t_mask();
    t_clock_err();
    t_block();
    t_readback();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule